// File: doc/BRIEF.md
# PHY Power Sequencer with Lock Timeout

This block is the control state machine that brings a combined PLL and data-lane PHY up and down. It accepts single-cycle command pulses (init, power-on, power-off, exit) and drives two power-down outputs, an LVDS enable and a one-cycle strobe that clears the PLL divider settings. Both power-down outputs use 1 for "powered down" and 0 for "running".

The mode input picks the power-on order. In MIPI mode the PLL is released first. The sequencer then polls the lock input until it is high, and only then releases the lanes. In LVDS mode the LVDS enable is set first, then the lanes and then the PLL are released. A master then waits for lock, while a slave finishes at once. Lock is sampled once every `POLL_US` pulses of a microsecond tick input. If no lock is seen within `TIMEOUT_US` ticks, the PLL is powered down again and a sticky error flag is raised.

`mode_lvds` and `slave` are captured when a command is accepted. Commands that arrive while a sequence runs are ignored. When more than one command is pulsed at the same time in idle, power-off wins, then init, then exit, then power-on.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, pll_pd=1, lane_pd=1, lvds_en=0, div_clr=0, busy=0, done=0 and err=0.
- R2: Init sets pll_pd to 1 one cycle before it sets lane_pd to 1, and done pulses together with the lane_pd step.
- R3: In MIPI mode (mode_lvds=0), power-on clears pll_pd, waits for lock, then clears lane_pd with a one-cycle done pulse.
- R4: Lock is sampled only on every POLL_US-th tick. A lock first seen on the sample at tick TIMEOUT_US still counts as success.
- R5: In LVDS mode (mode_lvds=1), power-on sets lvds_en, then clears lane_pd, then clears pll_pd, one step per cycle. A master then waits for lock and pulses done.
- R6: An LVDS slave (slave=1) pulses done in the same cycle pll_pd clears, with no lock wait.
- R7: Power-off sets pll_pd to 1, then lane_pd to 1 on the next cycle. In LVDS mode lvds_en clears on that second cycle, and done pulses with it.
- R8: Exit gives a single-cycle div_clr pulse together with done.
- R9: With no lock sampled by tick TIMEOUT_US, pll_pd returns to 1, err rises and busy falls without done. err stays high until the next accepted power-on.
- R10: busy is high from the cycle after a command is accepted until the sequence ends. Commands that arrive while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_init | input | 1 | Init command pulse |
| cmd_on | input | 1 | Power-on command pulse |
| cmd_off | input | 1 | Power-off command pulse |
| cmd_exit | input | 1 | Exit command pulse (clear dividers) |
| mode_lvds | input | 1 | 1 selects LVDS, 0 selects MIPI |
| slave | input | 1 | LVDS slave: skip lock wait |
| pll_lock | input | 1 | PLL lock indication |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| pll_pd | output | 1 | PLL power-down, 1 = off |
| lane_pd | output | 1 | Lane power-down, 1 = off |
| lvds_en | output | 1 | LVDS driver enable |
| div_clr | output | 1 | Clear strobe for PLL divider registers |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed (one cycle) |
| err | output | 1 | Sticky lock-timeout flag |

## Verification
A state step taken out of order shows up within one cycle as a power-down output changing before its partner, for example lanes released while the PLL is still off. An off-by-one in the poll divider or in the poll count moves the lane release or the timeout by a full poll period. The bench therefore checks the outputs in the exact cycle on both sides of the lock sample and on both sides of the last poll. A lost mode capture shows as the wrong release order in the cycles right after the command.

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
  parameter int POLL_US    = 10,
  parameter int TIMEOUT_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_init,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic cmd_exit,
  input  logic mode_lvds,
  input  logic slave,
  input  logic pll_lock,
  input  logic tick_us,
  output logic pll_pd,
  output logic lane_pd,
  output logic lvds_en,
  output logic div_clr,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int NPOLL = TIMEOUT_US / POLL_US;
  localparam int SW = (POLL_US > 1) ? $clog2(POLL_US) : 1;
  localparam int PW = (NPOLL > 1) ? $clog2(NPOLL) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_INIT1, S_INIT2, S_ON_PLL, S_WAIT, S_ON_LANE,
    S_LV_EN, S_LV_LANE, S_LV_PLL, S_OFF1, S_OFF2, S_EXIT, S_FAIL
  } st_t;

  st_t           st;
  logic          mode_q, slave_q;
  logic [SW-1:0] sub;
  logic [PW-1:0] polls;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pll_pd  <= 1'b1;
      lane_pd <= 1'b1;
      lvds_en <= 1'b0;
      div_clr <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      mode_q  <= 1'b0;
      slave_q <= 1'b0;
      sub     <= '0;
      polls   <= '0;
    end else begin
      done    <= 1'b0;
      div_clr <= 1'b0;
      case (st)
        S_IDLE: begin
          mode_q  <= mode_lvds;
          slave_q <= slave;
          if (cmd_off)       st <= S_OFF1;
          else if (cmd_init) st <= S_INIT1;
          else if (cmd_exit) st <= S_EXIT;
          else if (cmd_on) begin
            err <= 1'b0;
            st  <= mode_lvds ? S_LV_EN : S_ON_PLL;
          end
        end
        S_INIT1: begin pll_pd <= 1'b1; st <= S_INIT2; end
        S_INIT2: begin lane_pd <= 1'b1; done <= 1'b1; st <= S_IDLE; end
        S_ON_PLL: begin
          pll_pd <= 1'b0;
          sub    <= '0;
          polls  <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: if (tick_us) begin
          if (sub == SW'(POLL_US - 1)) begin
            sub <= '0;
            if (pll_lock) begin
              if (mode_q) begin done <= 1'b1; st <= S_IDLE; end
              else st <= S_ON_LANE;
            end else if (polls == PW'(NPOLL - 1)) st <= S_FAIL;
            else polls <= polls + 1'b1;
          end else sub <= sub + 1'b1;
        end
        S_ON_LANE: begin lane_pd <= 1'b0; done <= 1'b1; st <= S_IDLE; end
        S_LV_EN:   begin lvds_en <= 1'b1; st <= S_LV_LANE; end
        S_LV_LANE: begin lane_pd <= 1'b0; st <= S_LV_PLL; end
        S_LV_PLL: begin
          pll_pd <= 1'b0;
          sub    <= '0;
          polls  <= '0;
          if (slave_q) begin done <= 1'b1; st <= S_IDLE; end
          else st <= S_WAIT;
        end
        S_OFF1: begin pll_pd <= 1'b1; st <= S_OFF2; end
        S_OFF2: begin
          lane_pd <= 1'b1;
          if (mode_q) lvds_en <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_EXIT: begin div_clr <= 1'b1; done <= 1'b1; st <= S_IDLE; end
        S_FAIL: begin pll_pd <= 1'b1; err <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2, R7: lanes are powered down only after the PLL already is
  p_lane_off_after_pll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_pd) |-> pll_pd);
  // R3: MIPI lanes are released only while the PLL runs
  p_mipi_lane_after_pll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lane_pd) && !mode_q) |-> !pll_pd);
  // R5: LVDS lanes are released only with the LVDS enable set
  p_lvds_en_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lane_pd) && mode_q) |-> lvds_en);
  p_exit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> !div_clr);
  p_fail_pll_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (pll_pd && !done));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_init = 0, cmd_on = 0, cmd_off = 0, cmd_exit = 0;
  logic mode_lvds = 0, slave = 0, pll_lock = 0, tick_us = 0;
  logic pll_pd, lane_pd, lvds_en, div_clr, busy, done, err;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phy_pwr_seq u_phy_pwr_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int c);
    @(negedge clk);
    case (c)
      0: cmd_init = 1;
      1: cmd_on   = 1;
      2: cmd_off  = 1;
      default: cmd_exit = 1;
    endcase
    @(negedge clk);
    {cmd_init, cmd_on, cmd_off, cmd_exit} = '0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_us = 1;
      @(negedge clk) tick_us = 0;
    end
  endtask

  task automatic t_reset;
    chk("R1 pll_pd", pll_pd, 1); chk("R1 lane_pd", lane_pd, 1);
    chk("R1 lvds_en", lvds_en, 0); chk("R1 div_clr", div_clr, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
  endtask

  task automatic t_mipi_on;
    mode_lvds = 0; pll_lock = 1;
    issue(1);
    @(negedge clk);
    chk("R3 pll released", pll_pd, 0); chk("R3 lanes held", lane_pd, 1);
    issue(2);  // ignored while busy
    @(negedge clk);
    chk("R10 off ignored pll", pll_pd, 0); chk("R10 busy", busy, 1);
    tick_n(9);
    chk("R4 no sample before poll", lane_pd, 1);
    tick_n(1);
    @(negedge clk);
    chk("R3 lanes released", lane_pd, 0); chk("R3 done", done, 1);
    chk("R10 busy low", busy, 0);
  endtask

  task automatic t_init;
    issue(0);
    @(negedge clk);
    chk("R2 pll off first", pll_pd, 1); chk("R2 lanes still on", lane_pd, 0);
    @(negedge clk);
    chk("R2 lanes off", lane_pd, 1); chk("R2 done", done, 1);
  endtask

  task automatic t_exit;
    issue(3);
    @(negedge clk);
    chk("R8 div_clr", div_clr, 1); chk("R8 done", done, 1);
    @(negedge clk);
    chk("R8 div_clr one cycle", div_clr, 0);
  endtask

  task automatic t_lvds_master_and_off;
    mode_lvds = 1; slave = 0; pll_lock = 1;
    issue(1);
    @(negedge clk);
    chk("R5 lvds_en first", lvds_en, 1); chk("R5 lanes held", lane_pd, 1);
    chk("R5 pll held", pll_pd, 1);
    @(negedge clk);
    chk("R5 lanes second", lane_pd, 0); chk("R5 pll still off", pll_pd, 1);
    @(negedge clk);
    chk("R5 pll third", pll_pd, 0); chk("R5 waiting", busy, 1);
    tick_n(10);
    chk("R5 done after lock", done, 1); chk("R5 idle", busy, 0);
    issue(2);
    @(negedge clk);
    chk("R7 pll off first", pll_pd, 1); chk("R7 lanes on", lane_pd, 0);
    chk("R7 lvds_en kept", lvds_en, 1);
    @(negedge clk);
    chk("R7 lanes off", lane_pd, 1); chk("R7 lvds_en cleared", lvds_en, 0);
    chk("R7 done", done, 1);
  endtask

  task automatic t_lvds_slave;
    mode_lvds = 1; slave = 1; pll_lock = 0;
    issue(1);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R6 pll released", pll_pd, 0); chk("R6 done no wait", done, 1);
    chk("R6 not busy", busy, 0);
    issue(2);
    @(negedge clk); @(negedge clk);
    mode_lvds = 0; slave = 0;
  endtask

  task automatic t_last_poll;
    pll_lock = 0;
    issue(1);
    @(negedge clk);
    tick_n(999);
    chk("R4 still waiting", busy, 1);
    pll_lock = 1;
    tick_n(1);
    @(negedge clk);
    chk("R4 last poll success", lane_pd, 0); chk("R4 no err", err, 0);
    issue(2);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_timeout;
    pll_lock = 0;
    issue(1);
    @(negedge clk);
    tick_n(999);
    chk("R9 no err yet", err, 0); chk("R9 busy", busy, 1);
    tick_n(1);
    @(negedge clk);
    chk("R9 err", err, 1); chk("R9 pll off", pll_pd, 1);
    chk("R9 idle", busy, 0); chk("R9 no done", done, 0);
    chk("R9 lanes off", lane_pd, 1);
    @(negedge clk);
    chk("R9 err sticky", err, 1);
    pll_lock = 1;
    issue(1);
    chk("R9 err cleared on power-on", err, 0);
    @(negedge clk);
    tick_n(10);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_mipi_on;
    t_init;
    t_exit;
    t_lvds_master_and_off;
    t_lvds_slave;
    t_last_poll;
    t_timeout;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule